// File: doc/BRIEF.md
# Snoop Hit Write-Back Responder

This block is the processor-side controller that answers a cache snoop from another bus master while the processor has handed over the bus. Once the bus is granted, an external snoop strobe is sampled together with a flag giving the cause of the snoop (a read or a write by the other master). The block then reports whether the snooped line holds modified data. On a modified hit it keeps the hit output asserted and waits for the hold request to be withdrawn. It then takes the bus back and writes the line out as a four-beat burst. Finally it releases the hit output, reports the new line state and grants the bus again if hold is still requested.

The tag lookup is reduced to one input, `line_dirty`, that says whether the snooped line is modified. No data, address or cache array is modelled. Control outputs follow the usual active-low bus convention.

Top module: `snoop_wb_responder`

## Requirements
- R1: After synchronous reset: hold_ack=0, hit_dirty_n=1, addr_stb_n=1, cache_n=1, wr_nrd=0, burst_last_n=1, upd_valid=0, upd_state=2'b00.
- R2: From idle, hold_ack is high after the first clock edge that samples hold_req high. With no snoop in progress, hold_ack is low after the first edge that samples hold_req low.
- R3: snoop_stb_n is sampled only at edges where hold_ack was already high through the preceding clock. A low strobe has no effect at any other time: while idle, during lookup, while a hit is reported, during the write-back and in the update cycle.
- R4: If the strobe is sampled low at edge k with line_dirty=1, hit_dirty_n is low after edge k+1, which is the second clock after the strobe is applied. It stays low until the write-back completes.
- R5: If the strobe is sampled with line_dirty=0, hit_dirty_n stays high and hold_ack stays high for as long as hold_req stays high.
- R6: While a hit is reported, hold_ack stays high as long as hold_req is high. At the first edge that samples hold_req low, hold_ack drops. For exactly that next clock, addr_stb_n=0, cache_n=0 and wr_nrd=1.
- R7: After the address clock comes the data phase. Each edge that samples burst_rdy_n low ends one beat, and burst_rdy_n during the address clock is ignored. burst_last_n is low only during the fourth beat. cache_n stays low and wr_nrd stays high through the data phase.
- R8: The write-back completes at the edge where burst_last_n and burst_rdy_n are both low. After that edge hit_dirty_n is high and upd_valid is high for one clock. upd_state is 2'b01 (shared) if the invalidate flag was 0 and 2'b00 (invalid) if it was 1.
- R9: hold_ack stays low from the hold release until completion, even if hold_req is raised again. If hold_req is sampled high in the update clock, hold_ack is high one clock after it. Otherwise hold_ack stays low.
- R10: snoop_inv and line_dirty are captured at the edge that accepts the strobe. Later changes to them do not affect the hit report or the reported state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req | input | 1 | Bus hold request from system logic |
| hold_ack | output | 1 | Bus hold acknowledge |
| snoop_stb_n | input | 1 | Snoop strobe, active low |
| snoop_inv | input | 1 | Snoop cause: 0 read, 1 write (invalidate) |
| line_dirty | input | 1 | Lookup result: snooped line is modified |
| hit_dirty_n | output | 1 | Modified-line hit, active low |
| addr_stb_n | output | 1 | Write-back address strobe, active low |
| cache_n | output | 1 | Cacheable burst indication, active low |
| wr_nrd | output | 1 | Write (1) / read (0) |
| burst_last_n | output | 1 | Last beat of burst, active low |
| burst_rdy_n | input | 1 | Burst beat ready, active low |
| upd_valid | output | 1 | One-clock pulse: new line state valid |
| upd_state | output | 2 | New line state: 01 shared, 00 invalid |

## Verification
The bench runs a full sweep over the snoop cause, clean versus modified line, zero to two extra clocks of hold before release, zero or one wait state per beat, and whether hold is requested again during the burst. Clean runs show that a miss leaves the bus granted. Modified runs check the hit timing, the address clock, the position of the last-beat flag and the state reported for each cause. The stall and wait variants show that the burst counts only ready beats and does not count elapsed clocks. The re-request variant shows that the grant returns only after completion. Strobes during idle, during a reported hit and in the clock the grant first rises must leave the outputs unchanged. The cause and dirty inputs are toggled after acceptance to show that they were captured.

// File: rtl/snoop_wb_pkg.sv
// Package: shared state encodings for the snoop write-back responder.
// Assumes: nothing beyond IEEE 1800-2017.
package snoop_wb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // bus owned by processor, no grant
        ST_GRANT,   // bus granted, snoop strobe sampled
        ST_LOOKUP,  // strobe accepted, lookup clock
        ST_HIT,     // modified hit reported, waiting for hold release
        ST_ADDR,    // write-back address clock
        ST_DATA,    // write-back data beats
        ST_UPDATE   // line state update, grant may return
    } wb_state_e;

    localparam logic [1:0] LINE_INVALID = 2'b00;
    localparam logic [1:0] LINE_SHARED  = 2'b01;
endpackage

// File: rtl/snoop_wb_beats.sv
// Module: counts ready beats of the write-back burst and flags the last one.
// Assumes: clear is held during the address clock; adv only while beats run.
module snoop_wb_beats #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic adv,
    output logic last_beat
);
    localparam int CW = (BEATS > 2) ? $clog2(BEATS) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(BEATS - 1);

    logic [CW-1:0] beat_q;

    // Beat index: reset by clear, advances on each ready beat.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) beat_q <= '0;
        else if (adv)        beat_q <= beat_q + 1'b1;
    end

    // Last-beat flag from the current index.
    always_comb last_beat = (beat_q == LAST_IDX);
endmodule

// File: rtl/snoop_wb_fsm.sv
// Module: sequencing of grant, snoop sampling, hit report, write-back, update.
// Assumes: snoop inputs are synchronous; last_beat comes from the beat counter.
module snoop_wb_fsm
    import snoop_wb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold_req,
    input  logic      snoop_stb_n,
    input  logic      snoop_inv,
    input  logic      line_dirty,
    input  logic      burst_rdy_n,
    input  logic      last_beat,
    output wb_state_e state_q,
    output logic      inv_q
);
    wb_state_e state_d;
    logic      dirty_q;
    logic      accept;

    // Strobe is taken only in the settled grant state.
    always_comb accept = (state_q == ST_GRANT) && !snoop_stb_n;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (hold_req) state_d = ST_GRANT;
            ST_GRANT:  if (accept) state_d = ST_LOOKUP;
                       else if (!hold_req) state_d = ST_IDLE;
            ST_LOOKUP: state_d = dirty_q ? ST_HIT : ST_GRANT;
            ST_HIT:    if (!hold_req) state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_DATA;
            ST_DATA:   if (last_beat && !burst_rdy_n) state_d = ST_UPDATE;
            ST_UPDATE: state_d = hold_req ? ST_GRANT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture snoop cause and lookup result at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q   <= 1'b0;
            dirty_q <= 1'b0;
        end else if (accept) begin
            inv_q   <= snoop_inv;
            dirty_q <= line_dirty;
        end
    end
endmodule

// File: rtl/snoop_wb_responder.sv
// Module: top of the snoop write-back responder; decodes bus outputs from state.
// Assumes: BEATS >= 2; all inputs synchronous to clk.
module snoop_wb_responder
    import snoop_wb_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_req,
    output logic       hold_ack,
    input  logic       snoop_stb_n,
    input  logic       snoop_inv,
    input  logic       line_dirty,
    output logic       hit_dirty_n,
    output logic       addr_stb_n,
    output logic       cache_n,
    output logic       wr_nrd,
    output logic       burst_last_n,
    input  logic       burst_rdy_n,
    output logic       upd_valid,
    output logic [1:0] upd_state
);
    wb_state_e state_q;
    logic      inv_q;
    logic      last_beat;
    logic      in_burst;

    snoop_wb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_req    (hold_req),
        .snoop_stb_n (snoop_stb_n),
        .snoop_inv   (snoop_inv),
        .line_dirty  (line_dirty),
        .burst_rdy_n (burst_rdy_n),
        .last_beat   (last_beat),
        .state_q     (state_q),
        .inv_q       (inv_q)
    );

    snoop_wb_beats #(.BEATS(BEATS)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_ADDR),
        .adv       ((state_q == ST_DATA) && !burst_rdy_n),
        .last_beat (last_beat)
    );

    // Output decode from the registered state.
    always_comb begin
        in_burst     = (state_q == ST_ADDR) || (state_q == ST_DATA);
        hold_ack     = (state_q == ST_GRANT) || (state_q == ST_LOOKUP) || (state_q == ST_HIT);
        hit_dirty_n  = !((state_q == ST_HIT) || in_burst);
        addr_stb_n   = (state_q != ST_ADDR);
        cache_n      = !in_burst;
        wr_nrd       = in_burst;
        burst_last_n = !((state_q == ST_DATA) && last_beat);
        upd_valid    = (state_q == ST_UPDATE);
        upd_state    = !upd_valid ? LINE_INVALID : (inv_q ? LINE_INVALID : LINE_SHARED);
    end
endmodule

// File: rtl/snoop_wb_chk.sv
// Module: protocol checker for the snoop write-back responder, bound to the top.
// Assumes: observes only top-level ports.
module snoop_wb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hold_req,
    input logic       hold_ack,
    input logic       snoop_stb_n,
    input logic       hit_dirty_n,
    input logic       addr_stb_n,
    input logic       cache_n,
    input logic       wr_nrd,
    input logic       burst_last_n,
    input logic       burst_rdy_n,
    input logic       upd_valid
);
    // R2
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> !$past(hold_req));

    // R4
    hit_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hit_dirty_n) |-> ($past(!snoop_stb_n, 2) && $past(hold_ack, 2)));

    // R6
    addr_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_stb_n |-> (!hold_ack && !cache_n && wr_nrd && burst_last_n));

    // R7
    last_in_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_last_n |-> (!hit_dirty_n && !cache_n && wr_nrd));

    // R8
    hit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_dirty_n) |-> ($past(!burst_last_n && !burst_rdy_n) && upd_valid));

    // R9
    no_early_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> !hold_ack);
endmodule

bind snoop_wb_responder snoop_wb_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_req     (hold_req),
    .hold_ack     (hold_ack),
    .snoop_stb_n  (snoop_stb_n),
    .hit_dirty_n  (hit_dirty_n),
    .addr_stb_n   (addr_stb_n),
    .cache_n      (cache_n),
    .wr_nrd       (wr_nrd),
    .burst_last_n (burst_last_n),
    .burst_rdy_n  (burst_rdy_n),
    .upd_valid    (upd_valid)
);

// File: tb/snoop_wb_responder_tb_top.sv
// Bench: sweep of snoop cause, dirty/clean, hold wait, beat stalls, re-request.
module snoop_wb_responder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold_req = 1'b0;
    logic       hold_ack;
    logic       snoop_stb_n = 1'b1;
    logic       snoop_inv = 1'b0;
    logic       line_dirty = 1'b0;
    logic       hit_dirty_n;
    logic       addr_stb_n;
    logic       cache_n;
    logic       wr_nrd;
    logic       burst_last_n;
    logic       burst_rdy_n = 1'b1;
    logic       upd_valid;
    logic [1:0] upd_state;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    snoop_wb_responder dut_i (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
        .snoop_stb_n(snoop_stb_n), .snoop_inv(snoop_inv), .line_dirty(line_dirty),
        .hit_dirty_n(hit_dirty_n), .addr_stb_n(addr_stb_n), .cache_n(cache_n),
        .wr_nrd(wr_nrd), .burst_last_n(burst_last_n), .burst_rdy_n(burst_rdy_n),
        .upd_valid(upd_valid), .upd_state(upd_state)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one rising edge, return at the following falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_snoop(input bit inv, input bit dirty, input int wait_n,
                             input int stall, input bit rehold);
        hold_req = 1'b1;
        tick();
        chk("R2 grant", {7'd0, hold_ack}, 8'd1);
        snoop_stb_n = 1'b0; snoop_inv = inv; line_dirty = dirty;
        tick();                                   // edge k: accepted
        snoop_stb_n = 1'b1; snoop_inv = ~inv; line_dirty = ~dirty;   // R10 scramble
        chk("R4 lookup clock", {7'd0, hit_dirty_n}, 8'd1);
        tick();                                   // edge k+1
        chk("R4/R5 hit report", {7'd0, hit_dirty_n}, {7'd0, ~dirty});
        chk("R5 grant kept", {7'd0, hold_ack}, 8'd1);
        if (!dirty) begin
            tick();
            chk("R5 clean hit high", {7'd0, hit_dirty_n}, 8'd1);
            chk("R5 clean grant", {6'd0, hold_ack, addr_stb_n}, 8'd3);
            hold_req = 1'b0;
            tick();
            chk("R2 release", {7'd0, hold_ack}, 8'd0);
            return;
        end
        for (int w = 0; w < wait_n; w++) begin
            snoop_stb_n = 1'b0; line_dirty = 1'b0;        // R3 strobe while hit reported
            tick();
            chk("R6 hit held", {5'd0, hold_ack, hit_dirty_n, addr_stb_n}, 8'b101);
        end
        snoop_stb_n = 1'b1;
        hold_req = 1'b0;
        tick();
        chk("R6 addr clock", {4'd0, hold_ack, addr_stb_n, cache_n, wr_nrd}, 8'b0001);
        burst_rdy_n = 1'b0;                              // R7 ignored in address clock
        hold_req = rehold;
        snoop_stb_n = 1'b0;                              // R3 strobe during write-back
        tick();
        snoop_stb_n = 1'b1;
        chk("R7 data phase", {3'd0, addr_stb_n, cache_n, wr_nrd, burst_last_n, hold_ack},
            8'b10110);
        for (int b = 0; b < 4; b++) begin
            for (int s = 0; s < stall; s++) begin
                burst_rdy_n = 1'b1;
                chk("R7 last flag (stall)", {7'd0, burst_last_n}, {7'd0, b != 3});
                tick();
            end
            burst_rdy_n = 1'b0;
            chk("R7 last flag", {7'd0, burst_last_n}, {7'd0, b != 3});
            chk("R9 no grant in burst", {6'd0, hold_ack, hit_dirty_n}, 8'd0);
            tick();
        end
        burst_rdy_n = 1'b1;
        chk("R8 hit released", {7'd0, hit_dirty_n}, 8'd1);
        chk("R8 update pulse", {7'd0, upd_valid}, 8'd1);
        chk("R8/R10 line state", {6'd0, upd_state}, inv ? 8'd0 : 8'd1);
        chk("R9 no grant at update", {7'd0, hold_ack}, 8'd0);
        tick();
        chk("R8 pulse single", {7'd0, upd_valid}, 8'd0);
        chk("R9 grant return", {7'd0, hold_ack}, {7'd0, rehold});
        hold_req = 1'b0;
        tick();
        chk("R2 final release", {7'd0, hold_ack}, 8'd0);
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 reset outputs",
            {1'b0, hold_ack, hit_dirty_n, addr_stb_n, cache_n, wr_nrd, burst_last_n, upd_valid},
            8'b00111010);
        chk("R1 reset state", {6'd0, upd_state}, 8'd0);
        rst_n = 1'b1;
        tick();
        // R3: strobe while idle is ignored
        snoop_stb_n = 1'b0; line_dirty = 1'b1;
        tick(); tick();
        chk("R3 idle strobe", {6'd0, hold_ack, hit_dirty_n}, 8'b01);
        // R3: strobe at the edge the grant first rises is ignored
        hold_req = 1'b1;
        tick();
        snoop_stb_n = 1'b1;
        tick(); tick();
        chk("R3 strobe at grant edge", {6'd0, hold_ack, hit_dirty_n}, 8'b11);
        hold_req = 1'b0;
        tick();
        chk("R2 drop", {7'd0, hold_ack}, 8'd0);
        for (int inv = 0; inv < 2; inv++)
            for (int dirty = 0; dirty < 2; dirty++)
                for (int w = 0; w < 3; w++)
                    for (int st = 0; st < 2; st++)
                        for (int rh = 0; rh < 2; rh++)
                            run_snoop(inv[0], dirty[0], w, st, rh[0]);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule